// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps one shift register with the outcomes of every branch that has resolved, in order. It also keeps a table of 2-bit saturating counters. A lookup forms a table index by folding the branch address together with the recent outcomes held in that register. The upper bit of the selected counter, registered, is the prediction. It appears one cycle after the lookup strobe.

When a branch resolves, the fetch side reports its address and its actual direction. The counter at the index that address maps to under the current history is then nudged toward that direction. After that, the outcome is shifted into the history. A single enable input turns the predictor off. While it is off, every prediction reads not-taken and resolve reports change nothing, so the learned state survives until the predictor is turned back on.

Top module: `gh_dir_predictor`

## Requirements
- R1: After reset, `pred_valid_o` is 0, every counter holds 1 (weakly not-taken, so every lookup predicts not-taken) and the history register is all zeros.
- R2: `pred_valid_o` is 1 exactly in the cycle after a cycle with `lookup_valid_i` high. `pred_taken_o` is 0 whenever `pred_valid_o` is 0.
- R3: The table index for an address is address bits [9:2] XOR history bits [7:0]. The table holds 256 counters.
- R4: A lookup predicts taken when its counter holds 2 or 3, and not-taken when it holds 0 or 1.
- R5: A resolve with outcome taken increments the counter and stops at 3. A resolve with outcome not-taken decrements the counter and stops at 0.
- R6: Every enabled resolve shifts the 12-bit history left by one, with its outcome (1 = taken) entering bit 0, whatever entry it trained.
- R7: A lookup made while `enable_i` is 0 predicts not-taken.
- R8: A resolve made while `enable_i` is 0 changes neither any counter nor the history.
- R9: When a lookup and a resolve select the same entry in the same cycle, the prediction reflects the counter value from before that update.
- R10: A resolve selects its counter from its own address and the history as it was before that resolve's outcome is shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | 1 = predictor active, 0 = force not-taken and freeze state |
| lookup_valid_i | input | 1 | A prediction is requested this cycle |
| lookup_pc_i | input | 8 | Branch address bits [9:2] of the lookup |
| resolve_valid_i | input | 1 | A conditional branch resolved this cycle |
| resolve_pc_i | input | 8 | Branch address bits [9:2] of the resolved branch |
| resolve_taken_i | input | 1 | Actual outcome of the resolved branch, 1 = taken |
| pred_valid_o | output | 1 | Prediction is present (one cycle after lookup) |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |

## Verification
A prediction is due on the clock edge that follows its lookup cycle. Counter and history changes from a resolve take effect on the edge that ends the resolve cycle, so they can first affect a lookup made in the next cycle. The bench applies every stimulus just after a falling edge and reads the prediction a short delay after the following rising edge. It keeps a reference counter table and history that are updated only after that read, which gives same-cycle lookups the pre-update value. Scenarios that need one entry hit repeatedly pick each address from the reference history, so the index stays fixed while the history moves.

// File: rtl/gh_pred_pkg.sv
package gh_pred_pkg;

    // Registered prediction presented at the block outputs.
    typedef struct packed {
        logic valid;
        logic taken;
    } pred_t;

endpackage

// File: rtl/gh_index_hash.sv
// Folds branch address bits with global history bits into a table index.
module gh_index_hash #(
    parameter int IDX_W  = 8,
    parameter int HUSE_W = 8
) (
    input  logic [IDX_W-1:0]  pc_bits_i,
    input  logic [HUSE_W-1:0] hist_bits_i,
    output logic [IDX_W-1:0]  idx_o
);

    logic [IDX_W-1:0] hist_ext;

    generate
        if (HUSE_W >= IDX_W) begin : g_hist_full
            assign hist_ext = hist_bits_i[IDX_W-1:0];
        end else begin : g_hist_pad
            assign hist_ext = {{(IDX_W-HUSE_W){1'b0}}, hist_bits_i};
        end
    endgenerate

    assign idx_o = pc_bits_i ^ hist_ext;

endmodule

// File: rtl/gh_history_reg.sv
// Shift register of resolved branch outcomes, newest in bit 0.
module gh_history_reg #(
    parameter int HIST_W = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              shift_en_i,
    input  logic              outcome_i,
    output logic [HIST_W-1:0] hist_o
);

    logic [HIST_W-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (shift_en_i) begin
            hist_d = {hist_q[HIST_W-2:0], outcome_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign hist_o = hist_q;

endmodule

// File: rtl/gh_counter_table.sv
// Table of saturating direction counters: one combinational read, one write.
module gh_counter_table #(
    parameter int IDX_W    = 8,
    parameter int CTR_W    = 2,
    parameter int CTR_INIT = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             rd_taken_o,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic             wr_taken_i
);

    localparam int DEPTH = 1 << IDX_W;
    localparam logic [CTR_W-1:0] CTR_MAX   = {CTR_W{1'b1}};
    localparam logic [CTR_W-1:0] CTR_MIN   = '0;
    localparam logic [CTR_W-1:0] CTR_RESET = CTR_W'(CTR_INIT);

    logic [CTR_W-1:0] ctr_q [DEPTH];
    logic [CTR_W-1:0] ctr_d [DEPTH];
    logic [CTR_W-1:0] wr_cur;
    logic [CTR_W-1:0] wr_next;

    // Saturating step of the selected counter.
    always_comb begin
        wr_cur  = ctr_q[wr_idx_i];
        wr_next = wr_cur;
        if (wr_taken_i) begin
            if (wr_cur != CTR_MAX) begin
                wr_next = wr_cur + 1'b1;
            end
        end else begin
            if (wr_cur != CTR_MIN) begin
                wr_next = wr_cur - 1'b1;
            end
        end
    end

    always_comb begin
        ctr_d = ctr_q;
        if (wr_en_i) begin
            ctr_d[wr_idx_i] = wr_next;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) begin
                ctr_q[i] <= CTR_RESET;
            end
        end else begin
            ctr_q <= ctr_d;
        end
    end

    // The upper bit of a counter is its direction.
    assign rd_taken_o = ctr_q[rd_idx_i][CTR_W-1];

endmodule

// File: rtl/gh_dir_predictor.sv
// Global-history branch direction predictor, top level.
module gh_dir_predictor #(
    parameter int IDX_W    = 8,
    parameter int PC_LSB   = 2,
    parameter int HIST_W   = 12,
    parameter int CTR_W    = 2,
    parameter int CTR_INIT = 1
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           enable_i,
    input  logic                           lookup_valid_i,
    input  logic [PC_LSB+IDX_W-1:PC_LSB]   lookup_pc_i,
    input  logic                           resolve_valid_i,
    input  logic [PC_LSB+IDX_W-1:PC_LSB]   resolve_pc_i,
    input  logic                           resolve_taken_i,
    output logic                           pred_valid_o,
    output logic                           pred_taken_o
);

    import gh_pred_pkg::*;

    localparam int HUSE_W = (HIST_W < IDX_W) ? HIST_W : IDX_W;

    logic [HIST_W-1:0] hist_q;
    logic [IDX_W-1:0]  lk_idx;
    logic [IDX_W-1:0]  rs_idx;
    logic              lk_ctr_taken;
    logic              train_en;
    pred_t             pred_d, pred_q;

    assign train_en = resolve_valid_i & enable_i;

    gh_index_hash #(
        .IDX_W  (IDX_W),
        .HUSE_W (HUSE_W)
    ) u_lookup_hash (
        .pc_bits_i   (lookup_pc_i),
        .hist_bits_i (hist_q[HUSE_W-1:0]),
        .idx_o       (lk_idx)
    );

    gh_index_hash #(
        .IDX_W  (IDX_W),
        .HUSE_W (HUSE_W)
    ) u_resolve_hash (
        .pc_bits_i   (resolve_pc_i),
        .hist_bits_i (hist_q[HUSE_W-1:0]),
        .idx_o       (rs_idx)
    );

    gh_counter_table #(
        .IDX_W    (IDX_W),
        .CTR_W    (CTR_W),
        .CTR_INIT (CTR_INIT)
    ) u_table (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rd_idx_i   (lk_idx),
        .rd_taken_o (lk_ctr_taken),
        .wr_en_i    (train_en),
        .wr_idx_i   (rs_idx),
        .wr_taken_i (resolve_taken_i)
    );

    gh_history_reg #(
        .HIST_W (HIST_W)
    ) u_history (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .shift_en_i (train_en),
        .outcome_i  (resolve_taken_i),
        .hist_o     (hist_q)
    );

    always_comb begin
        pred_d.valid = lookup_valid_i;
        pred_d.taken = lookup_valid_i & enable_i & lk_ctr_taken;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pred_q <= '0;
        end else begin
            pred_q <= pred_d;
        end
    end

    assign pred_valid_o = pred_q.valid;
    assign pred_taken_o = pred_q.taken;

endmodule

// File: rtl/gh_dir_predictor_chk.sv
// Temporal checks on the predictor, attached with bind.
module gh_dir_predictor_chk #(
    parameter int HIST_W = 12
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              enable_i,
    input logic              lookup_valid_i,
    input logic              resolve_valid_i,
    input logic              resolve_taken_i,
    input logic              pred_valid_o,
    input logic              pred_taken_o,
    input logic [HIST_W-1:0] hist_q
);

    p_valid_after_lookup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lookup_valid_i |=> pred_valid_o);

    p_no_valid_when_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lookup_valid_i |=> !pred_valid_o);

    p_taken_needs_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pred_valid_o |-> !pred_taken_o);

    p_disabled_not_taken_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lookup_valid_i && !enable_i) |=> !pred_taken_o);

    p_hist_newest_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (resolve_valid_i && enable_i) |=> (hist_q[0] == $past(resolve_taken_i)));

    p_hist_shifted_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (resolve_valid_i && enable_i) |=> (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])));

    p_hist_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(resolve_valid_i && enable_i) |=> $stable(hist_q));

endmodule

bind gh_dir_predictor gh_dir_predictor_chk #(
    .HIST_W (HIST_W)
) u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .enable_i        (enable_i),
    .lookup_valid_i  (lookup_valid_i),
    .resolve_valid_i (resolve_valid_i),
    .resolve_taken_i (resolve_taken_i),
    .pred_valid_o    (pred_valid_o),
    .pred_taken_o    (pred_taken_o),
    .hist_q          (hist_q)
);

// File: tb/tb_gh_dir_predictor.sv
`timescale 1ns/1ps
module tb_gh_dir_predictor;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       enable;
    logic       lk_v;
    logic [9:2] lk_pc;
    logic       rs_v;
    logic [9:2] rs_pc;
    logic       rs_t;
    logic       pred_valid;
    logic       pred_taken;

    int checks   = 0;
    int failures = 0;

    // Reference state built from the requirements.
    logic [1:0]  ref_tbl [256];
    logic [11:0] ref_hist;
    logic        last_taken;

    always #2.5 clk = ~clk;

    gh_dir_predictor dut (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .enable_i        (enable),
        .lookup_valid_i  (lk_v),
        .lookup_pc_i     (lk_pc),
        .resolve_valid_i (rs_v),
        .resolve_pc_i    (rs_pc),
        .resolve_taken_i (rs_t),
        .pred_valid_o    (pred_valid),
        .pred_taken_o    (pred_taken)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pc_for(input logic [7:0] idx);
        return idx ^ ref_hist[7:0];
    endfunction

    task automatic ref_clear();
        for (int i = 0; i < 256; i++) ref_tbl[i] = 2'd1;
        ref_hist = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; enable = 1'b1; lk_v = 1'b0; lk_pc = '0;
        rs_v = 1'b0; rs_pc = '0; rs_t = 1'b0;
        ref_clear();
        @(negedge clk);
        chk(pred_valid, 1'b0, "R1 valid in reset");
        chk(pred_taken, 1'b0, "R1 taken in reset");
        rst_n = 1'b1;
    endtask

    // One cycle of stimulus; prediction checked after the next rising edge.
    task automatic cyc(input logic lv, input logic [7:0] lpc, input logic rv,
                       input logic [7:0] rpc, input logic rt, input logic en,
                       input string req);
        logic       exp_t;
        logic [7:0] ri;
        @(negedge clk);
        lk_v = lv; lk_pc = lpc; rs_v = rv; rs_pc = rpc; rs_t = rt; enable = en;
        exp_t = lv && en && (ref_tbl[lpc ^ ref_hist[7:0]] >= 2'd2);
        @(posedge clk);
        #1;
        chk(pred_valid, lv, {req, " valid (R2)"});
        chk(pred_taken, exp_t, {req, " taken"});
        last_taken = pred_taken;
        if (rv && en) begin
            ri = rpc ^ ref_hist[7:0];
            if (rt && ref_tbl[ri] != 2'd3) ref_tbl[ri] = ref_tbl[ri] + 2'd1;
            if (!rt && ref_tbl[ri] != 2'd0) ref_tbl[ri] = ref_tbl[ri] - 2'd1;
            ref_hist = {ref_hist[10:0], rt};
        end
    endtask

    task automatic idle();
        cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, "R2 idle");
    endtask

    task automatic t_reset();
        do_reset();
        idle();
        for (int i = 0; i < 8; i++) begin
            cyc(1'b1, 8'(i * 37), 1'b0, 8'h00, 1'b0, 1'b1, "R1 reset lookup");
            chk(last_taken, 1'b0, "R1 weak not-taken after reset");
        end
    endtask

    task automatic t_sat_high();
        do_reset();
        for (int i = 0; i < 5; i++)
            cyc(1'b0, 8'h00, 1'b1, pc_for(8'h5A), 1'b1, 1'b1, "R5 train up");
        cyc(1'b0, 8'h00, 1'b1, pc_for(8'h5A), 1'b0, 1'b1, "R5 one down");
        cyc(1'b1, pc_for(8'h5A), 1'b0, 8'h00, 1'b0, 1'b1, "R5 sat high");
        chk(last_taken, 1'b1, "R5 counter saturated at 3");
        cyc(1'b0, 8'h00, 1'b1, pc_for(8'h5A), 1'b0, 1'b1, "R5 down");
        cyc(1'b1, pc_for(8'h5A), 1'b0, 8'h00, 1'b0, 1'b1, "R4 value 1");
        chk(last_taken, 1'b0, "R4 value 1 predicts not-taken");
    endtask

    task automatic t_sat_low();
        do_reset();
        for (int i = 0; i < 3; i++)
            cyc(1'b0, 8'h00, 1'b1, pc_for(8'hC3), 1'b0, 1'b1, "R5 train down");
        cyc(1'b0, 8'h00, 1'b1, pc_for(8'hC3), 1'b1, 1'b1, "R5 up once");
        cyc(1'b1, pc_for(8'hC3), 1'b0, 8'h00, 1'b0, 1'b1, "R5 sat low");
        chk(last_taken, 1'b0, "R5 counter saturated at 0");
        cyc(1'b0, 8'h00, 1'b1, pc_for(8'hC3), 1'b1, 1'b1, "R5 up again");
        cyc(1'b1, pc_for(8'hC3), 1'b0, 8'h00, 1'b0, 1'b1, "R4 value 2");
        chk(last_taken, 1'b1, "R4 value 2 predicts taken");
    endtask

    task automatic t_history();
        do_reset();
        cyc(1'b0, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1, "R10 train entry 0");
        cyc(1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, "R3 pc 0 after shift");
        chk(last_taken, 1'b0, "R3 R6 R10 pc 0 maps to entry 1");
        cyc(1'b1, 8'h01, 1'b0, 8'h00, 1'b0, 1'b1, "R3 pc 1 after shift");
        chk(last_taken, 1'b1, "R3 R6 R10 pc 1 maps to entry 0");
        // Unrelated not-taken branch still shifts history: pc 1 now maps to entry 3.
        cyc(1'b0, 8'h00, 1'b1, 8'h80, 1'b0, 1'b1, "R6 other branch");
        cyc(1'b1, 8'h02, 1'b0, 8'h00, 1'b0, 1'b1, "R6 history 2");
        chk(last_taken, 1'b1, "R6 pc 2 maps to entry 0");
    endtask

    task automatic t_disable();
        do_reset();
        for (int i = 0; i < 2; i++)
            cyc(1'b0, 8'h00, 1'b1, pc_for(8'h33), 1'b1, 1'b1, "R5 train");
        cyc(1'b1, pc_for(8'h33), 1'b0, 8'h00, 1'b0, 1'b0, "R7 disabled lookup");
        chk(last_taken, 1'b0, "R7 disabled predicts not-taken");
        for (int i = 0; i < 3; i++)
            cyc(1'b0, 8'h00, 1'b1, pc_for(8'h33), 1'b0, 1'b0, "R8 ignored resolve");
        cyc(1'b1, pc_for(8'h33), 1'b0, 8'h00, 1'b0, 1'b1, "R8 re-enabled");
        chk(last_taken, 1'b1, "R8 state kept while disabled");
    endtask

    task automatic t_collision();
        do_reset();
        cyc(1'b1, 8'h10, 1'b1, 8'h10, 1'b1, 1'b1, "R9 same entry");
        chk(last_taken, 1'b0, "R9 lookup sees pre-update value");
        cyc(1'b1, pc_for(8'h10), 1'b0, 8'h00, 1'b0, 1'b1, "R9 next cycle");
        chk(last_taken, 1'b1, "R9 update visible next cycle");
    endtask

    task automatic t_mixed();
        logic [15:0] lfsr = 16'hACE1;
        do_reset();
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0], {lfsr[3:1], 5'd0} ^ 8'(i & 3), lfsr[4],
                {lfsr[7:5], 5'd0} ^ 8'(i & 3), lfsr[8] | lfsr[9],
                (lfsr[15:12] != 4'd0), "R3 R4 R5 R6 R8 mixed");
        end
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; enable = 1'b1; lk_v = 1'b0; lk_pc = '0;
        rs_v = 1'b0; rs_pc = '0; rs_t = 1'b0; last_taken = 1'b0;
        ref_clear();
        t_reset();
        t_sat_high();
        t_sat_low();
        t_history();
        t_disable();
        t_collision();
        t_mixed();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule